// File: doc/BRIEF.md
# Byte-wide SPI master with register access

The block is an SPI master peripheral that software drives through two 32-bit registers on a simple single-cycle register bus. The control word at offset 0x0 carries three chip-select levels, a loopback enable, a start strobe and a clock divider. The data word at offset 0x4 takes the byte to send and, once the exchange is over, gives back the byte received.

One start write moves exactly one byte in SPI mode 3. Software polls the busy flag, which it reads at the strobe's own bit position. The chip-select pins follow register bits directly, so software frames a multi-byte message by holding a select low across several single-byte commands. Every control write replaces the whole word: the divider, the selects and the loopback bit take their new values at the same moment as the strobe.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the chip-select outputs are all high and SCLK is high. The control word reads 0xF800_0015: divider 31, loopback off, busy clear, all select bits 1. The data word reads 0.
- R2: Bus address bit 2 selects the register: 0 is the control word and 1 is the data word. A data-word read returns the received byte in bits 7:0, with bits 31:8 zero. A data write while idle stores bits 7:0 as the next transmit byte.
- R3: A control write with bit 1 set while idle starts a one-byte exchange. The busy flag reads 1 in control bit 1 from the cycle after that write. It reads 0 again exactly 16*HALF_BASE*(D+1) cycles after the write, with HALF_BASE=5 by default.
- R4: The exchange uses SPI mode 3 with the most significant bit first. SCLK idles high. MOSI changes on the falling SCLK edge and the input is sampled on the rising edge. The byte received is the eight sampled bits in arrival order.
- R5: Chip-select output n follows control bit 2*n (bits 0, 2, 4) from the cycle after a control write. A bit value of 1 drives the line high (inactive) and 0 drives it low.
- R6: With control bit 3 set, the received byte equals the transmitted byte and the MISO input has no effect.
- R7: Control bits 31:27 hold the divider D. Each SCLK half period lasts HALF_BASE*(D+1) clock cycles.
- R8: A control write during an exchange updates the chip-select, loopback and divider fields but does not restart the shifter. The busy time stays the one set by the original start.
- R9: A data-word write during an exchange is ignored. The byte read back afterwards is the received byte.
- R10: Control readback holds the select bits at 0, 2 and 4, busy at bit 1, loopback at bit 3 and the divider at 31:27. All other bits read 0, and bits written to them are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; bit 2 selects the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
The byte exchange is run with several pairs of transmit and slave bytes. These include alternating bits, all ones against all zeros, and single-bit-edge values such as 0x81. This separates a correct MSB-first order from a bit-reversed or shifted one, in both directions on the wire. The same vectors are run with divider values 0 to 3, which tells a correct half-period scaling apart from an off-by-one count. Loopback vectors pair a slave byte different from the transmit byte, so a path that still listens to MISO shows up. Directed tests write control and data words in the middle of a transfer and separate a restarted or corrupted exchange from one that continues.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_CS     = 3;
  localparam int unsigned DIV_W      = 5;
  localparam int unsigned DIV_LSB    = 27;
  localparam int unsigned STROBE_BIT = 1;
  localparam int unsigned LOOP_BIT   = 3;
  localparam int unsigned BIT_CNT_W  = $clog2(BYTE_W);
endpackage

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
  import spi_byte_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic [BYTE_W-1:0]    rx_byte,
  output logic [NUM_CS-1:0]    cs_n,
  output logic                 loop_en,
  output logic [DIV_W-1:0]     div,
  output logic [BYTE_W-1:0]    tx_byte,
  output logic                 start
);
  localparam int unsigned SEL_BIT = 2;

  logic              ctrl_wr, data_wr;
  logic [NUM_CS-1:0] cs_wr;
  logic [NUM_CS-1:0] cs_q, cs_d;
  logic              loop_q, loop_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              data_en;
  logic [WORD_W-1:0] ctrl_view;

  assign ctrl_wr = bus_sel & bus_wr & ~bus_addr[SEL_BIT];
  assign data_wr = bus_sel & bus_wr &  bus_addr[SEL_BIT];

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs_field
    assign cs_wr[n] = bus_wdata[2*n];
  end

  assign start = ctrl_wr & bus_wdata[STROBE_BIT] & ~busy;

  always_comb begin
    cs_d    = cs_wr;
    loop_d  = bus_wdata[LOOP_BIT];
    div_d   = bus_wdata[DIV_LSB +: DIV_W];
    data_en = done | (data_wr & ~busy);
    data_d  = done ? rx_byte : bus_wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      loop_q <= 1'b0;
      div_q  <= '1;
    end else if (ctrl_wr) begin
      cs_q   <= cs_d;
      loop_q <= loop_d;
      div_q  <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_comb begin
    ctrl_view = '0;
    for (int n = 0; n < NUM_CS; n++) begin
      ctrl_view[2*n] = cs_q[n];
    end
    ctrl_view[STROBE_BIT]          = busy;
    ctrl_view[LOOP_BIT]            = loop_q;
    ctrl_view[DIV_LSB +: DIV_W]    = div_q;
  end

  assign bus_rdata = bus_addr[SEL_BIT] ? {{(WORD_W-BYTE_W){1'b0}}, data_q} : ctrl_view;
  assign cs_n      = cs_q;
  assign loop_en   = loop_q;
  assign div       = div_q;
  assign tx_byte   = data_q;
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer
  import spi_byte_pkg::*;
#(
  parameter int unsigned HALF_BASE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int unsigned MAX_HALF = HALF_BASE * (2 ** DIV_W);
  localparam int unsigned CNT_W    = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             cnt_en;

  assign lim  = CNT_W'(HALF_BASE * (int'(div) + 1) - 1);
  assign tick = run & (cnt_q >= lim);

  always_comb begin
    cnt_en = run | (cnt_q != '0);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift
  import spi_byte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              loop_en,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic                 busy_q, busy_d;
  logic                 sclk_q, sclk_d;
  logic                 mosi_q, mosi_d;
  logic [BYTE_W-1:0]    tx_sr_q, tx_sr_d;
  logic [BYTE_W-1:0]    rx_sr_q, rx_sr_d;
  logic [BIT_CNT_W-1:0] bit_q, bit_d;
  logic                 in_bit, rise, fall, step;

  assign in_bit  = loop_en ? mosi_q : miso;
  assign fall    = busy_q & tick &  sclk_q;
  assign rise    = busy_q & tick & ~sclk_q;
  assign rx_byte = {rx_sr_q[BYTE_W-2:0], in_bit};
  assign done    = rise & (bit_q == LAST_BIT);
  assign step    = start | fall | rise;

  always_comb begin
    busy_d  = busy_q;
    sclk_d  = sclk_q;
    mosi_d  = mosi_q;
    tx_sr_d = tx_sr_q;
    rx_sr_d = rx_sr_q;
    bit_d   = bit_q;
    if (start && !busy_q) begin
      busy_d  = 1'b1;
      sclk_d  = 1'b1;
      tx_sr_d = tx_byte;
      bit_d   = '0;
    end else if (fall) begin
      sclk_d  = 1'b0;
      mosi_d  = tx_sr_q[BYTE_W-1];
      tx_sr_d = {tx_sr_q[BYTE_W-2:0], 1'b0};
    end else if (rise) begin
      sclk_d  = 1'b1;
      rx_sr_d = rx_byte;
      bit_d   = bit_q + 1'b1;
      if (bit_q == LAST_BIT) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b1;
      mosi_q  <= 1'b1;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      bit_q   <= '0;
    end else if (step) begin
      busy_q  <= busy_d;
      sclk_q  <= sclk_d;
      mosi_q  <= mosi_d;
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
      bit_q   <= bit_d;
    end
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = mosi_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int unsigned HALF_BASE = 5,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [2:0]        spi_cs_n
);
  logic              busy, done, start, tick, loop_en;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [DIV_W-1:0]  div;

  spi_byte_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .done      (done),
    .rx_byte   (rx_byte),
    .cs_n      (spi_cs_n),
    .loop_en   (loop_en),
    .div       (div),
    .tx_byte   (tx_byte),
    .start     (start)
  );

  spi_half_timer #(.HALF_BASE(HALF_BASE)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div   (div),
    .tick  (tick)
  );

  spi_byte_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tick    (tick),
    .tx_byte (tx_byte),
    .loop_en (loop_en),
    .miso    (spi_miso),
    .busy    (busy),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (done),
    .rx_byte (rx_byte)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              busy,
  input logic              spi_sclk,
  input logic [2:0]        spi_cs_n
);
  logic ctrl_wr;
  assign ctrl_wr = bus_sel & bus_wr & ~bus_addr[2];

  // R3: an idle strobe write makes the engine busy in the next cycle
  a_r3_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[1] && !busy) |=> busy);

  // R4: SCLK rests high whenever no byte is moving
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_sclk);

  // R4: SCLK only toggles during an exchange
  a_r4_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sclk) |-> (busy || $past(busy)));

  // R5: selects take the written even bits one cycle after a control write
  a_r5_cs_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (spi_cs_n == {$past(bus_wdata[4]), $past(bus_wdata[2]), $past(bus_wdata[0])}));

  // R8: a strobe during an exchange leaves the engine busy (no restart gap)
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy && spi_sclk && $past(spi_sclk)) |=> busy);
endmodule

bind spi_byte_master spi_byte_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .busy      (busy),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;
  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs_n;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // Mode 3 slave model: shifts out on falling edges, captures on rising edges
  logic [7:0] sl_byte = 8'h00;
  logic [7:0] sl_rx = 8'h00;
  logic [2:0] fall_cnt = 3'd0;
  logic [2:0] sl_idx;
  always @(negedge spi_sclk) fall_cnt <= fall_cnt + 3'd1;
  always @(posedge spi_sclk) sl_rx <= {sl_rx[6:0], spi_mosi};
  assign sl_idx   = 3'd0 - fall_cnt;
  assign spi_miso = sl_byte[sl_idx];

  // Vectors: [31:24] tx, [23:16] slave byte, [15:8] expected rx, [7] loopback, [4:0] divider
  localparam logic [31:0] VEC [6] = '{
    32'hA5_3C_3C_00,
    32'h00_FF_FF_00,
    32'hFF_00_00_01,
    32'h81_7E_81_80,
    32'h5A_C3_C3_02,
    32'h96_11_96_83
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input logic [31:0] ctrl,
                      input int mc_at, input logic [31:0] mc_val,
                      input int md_at, input logic [31:0] md_val,
                      output int cycles, output logic [31:0] rx,
                      output logic [2:0] cs_mid, output bit first_busy);
    int c;
    bit b;
    sl_byte = sl;
    cs_mid = 3'bxxx;
    first_busy = 1'b0;
    bus_write(3'h4, {24'h0, tx});
    bus_write(3'h0, ctrl);
    c = 0;
    while (c < 6000) begin
      if (c == mc_at) begin
        bus_write(3'h0, mc_val); c++;
      end else if (c == md_at) begin
        bus_write(3'h4, md_val); c++;
      end else begin
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'h0;
        #1 b = bus_rdata[1];
        if (c == 0) first_busy = b;
        if (c == mc_at + 1) cs_mid = spi_cs_n;
        @(negedge clk);
        bus_sel = 1'b0;
        if (!b) break;
        c++;
      end
    end
    cycles = c;
    bus_read(3'h4, rx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    logic [31:0] rx;
    logic [2:0] csm;
    bit fb;

    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 3'h0; bus_wdata = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(spi_cs_n == 3'b111, "R1", "cs_n after reset", {29'h0, spi_cs_n}, 32'h7);
    chk(spi_sclk == 1'b1, "R1", "sclk after reset", {31'h0, spi_sclk}, 32'h1);
    bus_read(3'h0, rd);
    chk(rd == 32'hF800_0015, "R1", "control after reset", rd, 32'hF800_0015);
    bus_read(3'h4, rd);
    chk(rd == 32'h0, "R1", "data after reset", rd, 32'h0);

    // R5: chip-select mapping
    bus_write(3'h0, 32'h0000_0010);
    chk(spi_cs_n == 3'b100, "R5", "cs_n for 0x10", {29'h0, spi_cs_n}, 32'h4);
    bus_write(3'h0, 32'h0000_0005);
    chk(spi_cs_n == 3'b011, "R5", "cs_n for 0x05", {29'h0, spi_cs_n}, 32'h3);

    // R10: readback fields, unused bits discarded
    bus_write(3'h0, 32'h7FFF_FFE5);
    bus_read(3'h0, rd);
    chk(rd == 32'h7800_0005, "R10", "control readback", rd, 32'h7800_0005);
    chk(spi_cs_n == 3'b011, "R10", "cs_n after wide write", {29'h0, spi_cs_n}, 32'h3);
    bus_write(3'h0, 32'h0000_001D);
    bus_read(3'h0, rd);
    chk(rd == 32'h0000_001D, "R10", "loopback bit readback", rd, 32'h1D);

    // Vector table: R2 R3 R4 R6 R7
    for (int i = 0; i < 6; i++) begin
      logic [7:0] tx, sl, ex;
      logic lp;
      logic [4:0] dv;
      logic [31:0] cw;
      int exp_cyc;
      tx = VEC[i][31:24]; sl = VEC[i][23:16]; ex = VEC[i][15:8];
      lp = VEC[i][7]; dv = VEC[i][4:0];
      cw = {dv, 27'h0} | {28'h0, lp, 3'b000} | 32'h14 | 32'h2;
      exp_cyc = 16 * HALF * (int'(dv) + 1);
      xfer(tx, sl, cw, -10, 32'h0, -10, 32'h0, cyc, rx, csm, fb);
      chk(fb == 1'b1, "R3", $sformatf("busy next cycle vec%0d", i), {31'h0, fb}, 32'h1);
      chk(cyc == exp_cyc, "R7", $sformatf("busy cycles vec%0d", i), cyc, exp_cyc);
      if (lp) chk(rx == {24'h0, ex}, "R6", $sformatf("loopback rx vec%0d", i), rx, {24'h0, ex});
      else    chk(rx == {24'h0, ex}, "R2", $sformatf("rx byte vec%0d", i), rx, {24'h0, ex});
      chk(sl_rx == tx, "R4", $sformatf("mosi byte vec%0d", i), {24'h0, sl_rx}, {24'h0, tx});
    end

    // R8 and R9: control and data writes during an exchange
    xfer(8'hC6, 8'h69, 32'h0000_0016, 20, 32'h0000_0003, 40, 32'h0000_0000, cyc, rx, csm, fb);
    chk(cyc == 80, "R8", "busy cycles with mid strobe", cyc, 80);
    chk(csm == 3'b001, "R8", "cs_n updated mid transfer", {29'h0, csm}, 32'h1);
    chk(rx == 32'h69, "R9", "rx after mid data write", rx, 32'h69);
    chk(sl_rx == 8'hC6, "R9", "mosi byte after mid data write", {24'h0, sl_rx}, 32'hC6);
    bus_read(3'h0, rd);
    chk(rd == 32'h0000_0001, "R8", "control after mid write", rd, 32'h1);
    chk(spi_sclk == 1'b1, "R4", "sclk idle after exchange", {31'h0, spi_sclk}, 32'h1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule